// File: doc/BRIEF.md
# Power-Budgeted Self-Test Session Sequencer

This block steps through a fixed table of self-test sessions for a small datapath made of registers, adders and multipliers. Every table entry names the resources that take part (an enable mask), how many cycles of test application the session needs, a seed for the pattern generators, the expected signature, and the multiplexer setting for the datapath. Each session runs in three phases. First the seed is shifted out serially while the shift enable is high. Next the test is applied for the session's own length, and any comparator mismatch is recorded. Last the signature is shifted in serially and compared with the expected value.

Before a session starts, the block adds up the power units of the resources in its mask, using per-resource costs given as parameters. The session runs only if that sum does not exceed the budget on the `budget` input. A session over the budget is skipped and raises a sticky error flag. The default table has two multiplier sessions and a merged one that holds both multipliers. The merged session runs only under a generous budget. Resources outside the running session get no clock enable, so they change no state. The multiplexer controls change only when a session opens or closes.

All pins are plain control and status pins. The serial seed and signature bits move one per cycle while `shift_en` is high, with no back-pressure. Software sequencing is a single `start` pulse. The block answers with `done`, `pass_all` and `err_budget`.

Top module: `bist_sess_ctrl`

## Requirements
- R1: Each run session begins with SEED_W cycles with `shift_en` high, in which `seed_bit` on the k-th cycle is bit k (LSB first) of the session's seed. It ends with SIG_W cycles with `shift_en` high, in which `sig_bit` is sampled as signature bit k (LSB first).
- R2: Between the two shift phases, `shift_en` is low for exactly the session's length in cycles. The default table uses 128 for the adder session and 512 for the multiplier sessions.
- R3: A session's cost is the sum of the per-resource power units over the set bits of its mask (default: bits 0-3 registers at 1, bits 4-5 adders at 1, bits 6-7 multipliers at 4). The session runs only when cost <= `budget`, and a cost equal to the budget is admitted.
- R4: `res_en` equals the running session's mask in all three of its phases and is all zero at every other time. `shift_en` is low outside sessions.
- R5: `mux_sel` takes the session's setting when the session opens, holds it unchanged through the whole session, and is zero between sessions.
- R6: Sessions are visited in table order from index 0. A session over the budget produces no enables, sets `err_budget`, and the sequence moves on to the next entry.
- R7: A session passes when `cmp_fail` was never high in a test-application cycle and the captured signature equals the expected one. `cmp_fail` during the shift phases is ignored. `pass_all` is the AND of the results of all sessions that ran, and is 1 when none ran.
- R8: `start` while idle clears `done`, `err_budget` and sets `pass_all` to 1. `busy` is high from then until `done` rises after the last table entry. `done` then stays high until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin the session table (accepted while idle) |
| budget | input | CW | Power-unit budget per session |
| cmp_fail | input | 1 | Output comparator mismatch from the tested modules |
| sig_bit | input | 1 | Serial signature bit from the signature register |
| res_en | output | NRES | Clock enable per register or module |
| shift_en | output | 1 | Seed or signature shift phase |
| seed_bit | output | 1 | Serial seed bit for the pattern generators |
| mux_sel | output | MUXW | Datapath multiplexer control for the session |
| busy | output | 1 | Table in progress |
| done | output | 1 | Table finished |
| pass_all | output | 1 | AND of the results of all sessions that ran |
| err_budget | output | 1 | At least one session was skipped for power |

## Verification
On every cycle, the assertions check four things. The multiplexer setting never moves inside a session. Enables and shifting are quiet in the idle, admission and advance states. A session only opens after its cost was within budget. The application counter stays under the session length. The bench scenarios cover what only whole runs can show: the exact mask and phase lengths of each session, the serial seed order, which sessions a given budget admits or skips, and how injected mismatches and corrupted signatures combine into the overall pass flag.

// File: rtl/bist_pkg.sv
package bist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ADMIT, ST_SEED, ST_APPLY, ST_UNLOAD, ST_NEXT
  } phase_t;
endpackage

// File: rtl/bist_cost.sv
// Sums per-resource power units over the set bits of a mask.
module bist_cost #(
  parameter int NRES = 8,
  parameter int PW   = 3,
  parameter int CW   = 7,
  parameter logic [NRES-1:0][PW-1:0] POWER = '0
) (
  input  logic [NRES-1:0] mask,
  output logic [CW-1:0]   cost
);
  logic [CW-1:0] part [NRES+1];
  assign part[0] = '0;
  for (genvar i = 0; i < NRES; i++) begin : g_acc
    assign part[i+1] = part[i] + (mask[i] ? CW'(POWER[i]) : '0);
  end
  assign cost = part[NRES];
endmodule

// File: rtl/bist_sig.sv
// Serial signature capture, LSB first, with compare on the final bit.
module bist_sig #(
  parameter int SIG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cap,
  input  logic             sig_bit,
  input  logic [SIG_W-1:0] golden,
  output logic             match
);
  logic [SIG_W-1:0] sr;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= '0;
    else if (cap) sr <= {sig_bit, sr[SIG_W-1:1]};
  end
  assign match = ({sig_bit, sr[SIG_W-1:1]} == golden);
endmodule

// File: rtl/bist_seq.sv
// Session sequencer: admission, three-phase session timing, result collection.
module bist_seq
  import bist_pkg::*;
#(
  parameter int NRES   = 8,
  parameter int NSESS  = 4,
  parameter int CW     = 7,
  parameter int LENW   = 10,
  parameter int SEED_W = 8,
  parameter int SIG_W  = 8,
  parameter int MUXW   = 4,
  parameter logic [NSESS-1:0][NRES-1:0]   SESS_MASK = '0,
  parameter logic [NSESS-1:0][LENW-1:0]   SESS_LEN  = '0,
  parameter logic [NSESS-1:0][SEED_W-1:0] SESS_SEED = '0,
  parameter logic [NSESS-1:0][SIG_W-1:0]  SESS_GOLD = '0,
  parameter logic [NSESS-1:0][MUXW-1:0]   SESS_MUX  = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CW-1:0]    budget,
  input  logic [CW-1:0]    cost,
  input  logic             cmp_fail,
  input  logic             match,
  output logic [NRES-1:0]  sel_mask,
  output logic [SIG_W-1:0] sel_gold,
  output logic             cap,
  output logic [NRES-1:0]  res_en,
  output logic             shift_en,
  output logic             seed_bit,
  output logic [MUXW-1:0]  mux_sel,
  output logic             busy,
  output logic             done,
  output logic             pass_all,
  output logic             err_budget
);
  localparam int IW  = (NSESS > 1) ? $clog2(NSESS) : 1;
  localparam int SIW = (SEED_W > 1) ? $clog2(SEED_W) : 1;

  phase_t          state;
  logic [IW-1:0]   idx;
  logic [LENW-1:0] cnt;
  logic            fail_r;
  logic            in_sess;
  logic [LENW-1:0] len_cur;

  assign sel_mask = SESS_MASK[idx];
  assign sel_gold = SESS_GOLD[idx];
  assign len_cur  = SESS_LEN[idx];
  assign in_sess  = (state == ST_SEED) || (state == ST_APPLY) || (state == ST_UNLOAD);
  assign res_en   = in_sess ? sel_mask : '0;
  assign shift_en = (state == ST_SEED) || (state == ST_UNLOAD);
  assign seed_bit = (state == ST_SEED) ? SESS_SEED[idx][cnt[SIW-1:0]] : 1'b0;
  assign cap      = (state == ST_UNLOAD);
  assign busy     = (state != ST_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      idx        <= '0;
      cnt        <= '0;
      fail_r     <= 1'b0;
      mux_sel    <= '0;
      done       <= 1'b0;
      pass_all   <= 1'b1;
      err_budget <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          idx        <= '0;
          done       <= 1'b0;
          pass_all   <= 1'b1;
          err_budget <= 1'b0;
          state      <= ST_ADMIT;
        end
        ST_ADMIT: if (cost <= budget) begin
          cnt     <= '0;
          fail_r  <= 1'b0;
          mux_sel <= SESS_MUX[idx];
          state   <= ST_SEED;
        end else begin
          err_budget <= 1'b1;
          state      <= ST_NEXT;
        end
        ST_SEED: if (cnt == LENW'(SEED_W - 1)) begin
          cnt   <= '0;
          state <= ST_APPLY;
        end else cnt <= cnt + 1'b1;
        ST_APPLY: begin
          if (cmp_fail) fail_r <= 1'b1;
          if (cnt == len_cur - 1'b1) begin
            cnt   <= '0;
            state <= ST_UNLOAD;
          end else cnt <= cnt + 1'b1;
        end
        ST_UNLOAD: if (cnt == LENW'(SIG_W - 1)) begin
          pass_all <= pass_all & ~fail_r & match;
          mux_sel  <= '0;
          state    <= ST_NEXT;
        end else cnt <= cnt + 1'b1;
        ST_NEXT: if (idx == IW'(NSESS - 1)) begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end else begin
          idx   <= idx + 1'b1;
          state <= ST_ADMIT;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_MUX_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sess && $past(in_sess)) |-> $stable(mux_sel)); // R5
  AST_QUIET_OUTSIDE: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sess |-> (res_en == '0 && !shift_en && mux_sel == '0)); // R4
  AST_ADMIT_BUDGET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state) == ST_ADMIT && state == ST_SEED) |-> $past(cost <= budget)); // R3
  AST_APPLY_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_APPLY) |-> (cnt < len_cur)); // R2
  AST_DONE_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(idx) == IW'(NSESS - 1))); // R8
  AST_PASS_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pass_all) |-> ($past(state) == ST_UNLOAD)); // R7
endmodule

// File: rtl/bist_sess_ctrl.sv
module bist_sess_ctrl #(
  parameter int NRES   = 8,
  parameter int NSESS  = 4,
  parameter int PW     = 3,
  parameter int CW     = PW + $clog2(NRES + 1),
  parameter int LENW   = 10,
  parameter int SEED_W = 8,
  parameter int SIG_W  = 8,
  parameter int MUXW   = 4,
  parameter logic [NRES-1:0][PW-1:0]      POWER     = {3'd4, 3'd4, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1},
  parameter logic [NSESS-1:0][NRES-1:0]   SESS_MASK = {8'hCF, 8'h8C, 8'h43, 8'h3F},
  parameter logic [NSESS-1:0][LENW-1:0]   SESS_LEN  = {10'd512, 10'd512, 10'd512, 10'd128},
  parameter logic [NSESS-1:0][SEED_W-1:0] SESS_SEED = {8'hC3, 8'h5A, 8'h96, 8'hE1},
  parameter logic [NSESS-1:0][SIG_W-1:0]  SESS_GOLD = {8'h3C, 8'hA5, 8'h69, 8'h1E},
  parameter logic [NSESS-1:0][MUXW-1:0]   SESS_MUX  = {4'h8, 4'h4, 4'h2, 4'h1}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CW-1:0]   budget,
  input  logic            cmp_fail,
  input  logic            sig_bit,
  output logic [NRES-1:0] res_en,
  output logic            shift_en,
  output logic            seed_bit,
  output logic [MUXW-1:0] mux_sel,
  output logic            busy,
  output logic            done,
  output logic            pass_all,
  output logic            err_budget
);
  logic [NRES-1:0]  sel_mask;
  logic [SIG_W-1:0] sel_gold;
  logic [CW-1:0]    cost;
  logic             cap;
  logic             match;

  bist_cost #(.NRES(NRES), .PW(PW), .CW(CW), .POWER(POWER)) u_cost (
    .mask(sel_mask), .cost(cost));

  bist_sig #(.SIG_W(SIG_W)) u_sig (
    .clk(clk), .rst_n(rst_n), .cap(cap), .sig_bit(sig_bit),
    .golden(sel_gold), .match(match));

  bist_seq #(
    .NRES(NRES), .NSESS(NSESS), .CW(CW), .LENW(LENW), .SEED_W(SEED_W),
    .SIG_W(SIG_W), .MUXW(MUXW), .SESS_MASK(SESS_MASK), .SESS_LEN(SESS_LEN),
    .SESS_SEED(SESS_SEED), .SESS_GOLD(SESS_GOLD), .SESS_MUX(SESS_MUX)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .budget(budget), .cost(cost),
    .cmp_fail(cmp_fail), .match(match), .sel_mask(sel_mask), .sel_gold(sel_gold),
    .cap(cap), .res_en(res_en), .shift_en(shift_en), .seed_bit(seed_bit),
    .mux_sel(mux_sel), .busy(busy), .done(done), .pass_all(pass_all),
    .err_budget(err_budget));
endmodule

// File: tb/tb_bist_sess_ctrl.sv
module tb_bist_sess_ctrl;
  localparam logic [7:0][2:0] POW  = {3'd4, 3'd4, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1, 3'd1};
  localparam logic [3:0][7:0] MASK = {8'hCF, 8'h8C, 8'h43, 8'h3F};
  localparam logic [3:0][9:0] LEN  = {10'd512, 10'd512, 10'd512, 10'd128};
  localparam logic [3:0][7:0] SEED = {8'hC3, 8'h5A, 8'h96, 8'hE1};
  localparam logic [3:0][7:0] GOLD = {8'h3C, 8'hA5, 8'h69, 8'h1E};
  localparam logic [3:0][3:0] MUX  = {4'h8, 4'h4, 4'h2, 4'h1};

  logic clk = 0, rst_n = 0, start = 0, cmp_fail = 0, sig_bit = 0;
  logic [6:0] budget = '0;
  logic [7:0] res_en;
  logic shift_en, seed_bit, busy, done, pass_all, err_budget;
  logic [3:0] mux_sel;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  bist_sess_ctrl dut (
    .clk(clk), .rst_n(rst_n), .start(start), .budget(budget), .cmp_fail(cmp_fail),
    .sig_bit(sig_bit), .res_en(res_en), .shift_en(shift_en), .seed_bit(seed_bit),
    .mux_sel(mux_sel), .busy(busy), .done(done), .pass_all(pass_all),
    .err_budget(err_budget));

  function automatic int cost_of(input logic [7:0] m);
    int c = 0;
    for (int i = 0; i < 8; i++) if (m[i]) c += int'(POW[i]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input int bud, input logic [3:0] bad, input logic [3:0] cf, input bit early);
    int adml[4];
    int nadm = 0, ptr = 0, es = 0, sk = 0, app = 0, cyc = 0;
    bit inwin = 0, exp_pass = 1, exp_err = 0;
    budget = 7'(bud);
    for (int s = 0; s < 4; s++) begin
      if (cost_of(MASK[s]) <= bud) begin
        adml[nadm] = s; nadm++;
        if (bad[s] || cf[s]) exp_pass = 0;
      end else exp_err = 1;
    end
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
    chk(done == 0 && busy == 1, "R8 start clears done, sets busy", {busy, done}, 2);
    while (1) begin
      @(negedge clk);
      cyc++;
      cmp_fail = 0; sig_bit = 0;
      if (done) break;
      if (cyc > 5000) begin chk(0, "R8 watchdog", cyc, 0); break; end
      if (res_en != 0) begin
        if (!inwin) begin
          inwin = 1; sk = 0; app = 0;
          chk(ptr < nadm, "R6 unexpected session", ptr, nadm);
          es = (ptr < nadm) ? adml[ptr] : 0;
        end
        chk(res_en == MASK[es], "R4 enables equal mask", res_en, MASK[es]);
        chk(mux_sel == MUX[es], "R5 mux held in session", mux_sel, MUX[es]);
        if (shift_en) begin
          if (sk < 8) begin
            chk(seed_bit == SEED[es][sk], "R1 seed bit", seed_bit, SEED[es][sk]);
            if (early && sk == 2) cmp_fail = 1;
          end else if (sk < 16) begin
            sig_bit = bad[es] ? ~GOLD[es][sk-8] : GOLD[es][sk-8];
          end
          sk++;
        end else begin
          app++;
          if (app == 5 && cf[es]) cmp_fail = 1;
        end
      end else begin
        chk(mux_sel == 0, "R5 mux zero between sessions", mux_sel, 0);
        chk(shift_en == 0, "R4 no shift outside session", shift_en, 0);
        if (inwin) begin
          chk(sk == 16, "R1 shift cycles", sk, 16);
          chk(app == int'(LEN[es]), "R2 apply length", app, LEN[es]);
          inwin = 0; ptr++;
        end
      end
    end
    chk(ptr == nadm, "R6 sessions run", ptr, nadm);
    chk(pass_all == exp_pass, "R7 pass_all", pass_all, exp_pass);
    chk(err_budget == exp_err, "R6 err_budget", err_budget, exp_err);
    chk(busy == 0, "R8 busy low at done", busy, 0);
    repeat (3) @(negedge clk);
    chk(done == 1, "R8 done held", done, 1);
  endtask

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    chk(res_en == 0 && shift_en == 0 && mux_sel == 0, "R4 reset quiet", res_en, 0);
    chk(done == 0 && busy == 0 && pass_all == 1 && err_budget == 0, "R8 reset status",
        {done, busy, pass_all, err_budget}, 2);
    rst_n = 1;
    @(negedge clk);
    run(12, 4'b0000, 4'b0000, 0);  // R3 merged session admitted at equal budget
    run(10, 4'b0001, 4'b0000, 0);  // R6 merged skipped; R7 bad signature
    run(10, 4'b0000, 4'b0100, 0);  // R7 mismatch in application
    run(6,  4'b0000, 4'b0000, 1);  // R3 cost equals budget; R7 early cmp_fail ignored
    run(5,  4'b0000, 4'b0000, 0);  // R6 everything skipped, pass stays 1
    for (int r = 0; r < 3; r++)
      run(int'($urandom_range(4, 14)), 4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)),
          4'($urandom_range(0, 15)) & 4'($urandom_range(0, 15)), bit'($urandom_range(0, 1)));
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule